// File: doc/BRIEF.md
# Receive-Line Baud Edge Meter

The block sits on a UART receive line and measures how many clock cycles pass between two chosen transitions of a known calibration character. Software clears the enable, writes a start-edge index and an end-edge index, and then sets the enable. The block passes the receive line through a synchronizer and numbers every transition it sees, rising or falling. Transition 0 is the first falling edge after enable, which is the leading edge of the start bit.

When the transition with the start index arrives, a cycle counter starts from zero. When the transition with the end index arrives, the counter stops, a one-cycle done strobe fires, and the count is held on the output. If the counter reaches its maximum first, a one-cycle timeout strobe fires instead. This happens under a held break, or when the character has too few transitions. Once a result exists, the block ignores the line until the enable is dropped and raised again. Working out a divisor from the count is left to software.

Top module: `baud_edge_meter`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with the enable low, count_o is 0 and both strobes are low. Dropping the enable clears the count and the edge numbering.
- R2: With the enable high, rising and falling transitions both take the next index. Index 0 goes to the first falling transition after enable, and rising transitions before it take no index.
- R3: count_o equals the number of clock cycles between the start-index transition and the end-index transition on rx_i. With 8 data bits sent LSB first, a 0x0D character with start 1 and end 5 gives 8 bit times. A 0x7F character with start 1 and end 3 also gives 8 bit times.
- R4: done_o is a single-cycle pulse, raised when the end-index transition is detected, and count_o holds the measured value from that cycle on.
- R5: If the count reaches 2^CNT_W-1 before the end transition, timeout_o pulses for one cycle and count_o holds all ones.
- R6: After done or timeout, further transitions change neither count_o nor the strobes until the enable is cleared and set again.
- R7: An end index less than or equal to the start index never completes, so the measurement ends in timeout.
- R8: done_o and timeout_o are never high in the same cycle.
- R9: The end index is 4 bits wide and reaches 15, so a measurement may span two back-to-back characters. The start index is 3 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Measurement enable; low clears all state |
| start_idx_i | input | 3 | Index of the transition that starts counting |
| stop_idx_i | input | 4 | Index of the transition that stops counting |
| rx_i | input | 1 | Asynchronous receive line, idle high |
| count_o | output | CNT_W (20) | Measured or held cycle count |
| done_o | output | 1 | One-cycle pulse when the end transition is reached |
| timeout_o | output | 1 | One-cycle pulse on counter overflow |

## Verification
A wrong edge number shows up as a count_o that is off by whole bit times, and only when done_o pulses, one cycle after the end transition leaves the synchronizer. A stuck or wrongly started counter shows as a count_o that differs from the bench's bit-time arithmetic, or as timeout_o firing where done_o was expected, 2^CNT_W-1 cycles after the start transition. Any leak of state past completion or disable shows on the very next cycle, as a moved count_o or an extra strobe.

// File: rtl/baud_meter_pkg.sv
package baud_meter_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_TOUT  = 2'd3
  } meter_state_e;
endpackage

// File: rtl/bm_rx_sync.sv
module bm_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= rx_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/bm_edge_index.sv
module bm_edge_index #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             edge_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic             started_q;
  logic [IDX_W-1:0] next_q;

  // before the first falling edge only a falling edge counts
  assign edge_o = started_q ? (rise_i | fall_i) : fall_i;
  assign idx_o  = started_q ? next_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      next_q    <= '0;
    end else if (!en_i) begin
      started_q <= 1'b0;
      next_q    <= '0;
    end else if (edge_o) begin
      started_q <= 1'b1;
      next_q    <= (idx_o == IDX_MAX) ? IDX_MAX : idx_o + IDX_ONE;
    end
  end
endmodule

// File: rtl/bm_span_counter.sv
module bm_span_counter
  import baud_meter_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int START_W = 3,
  parameter int STOP_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               edge_i,
  input  logic [STOP_W-1:0]  idx_i,
  input  logic [START_W-1:0] start_idx_i,
  input  logic [STOP_W-1:0]  stop_idx_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               done_o,
  output logic               timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meter_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              tout_q;
  logic [STOP_W-1:0] start_ext;
  logic              hit_start;
  logic              hit_stop;

  assign start_ext = {{(STOP_W-START_W){1'b0}}, start_idx_i};
  assign hit_start = edge_i && (idx_i == start_ext);
  assign hit_stop  = edge_i && (idx_i == stop_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tout_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_ARMED;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_ARMED: if (hit_start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
          ST_RUN: begin
            if (cnt_q == CNT_MAX) begin
              state_q <= ST_TOUT;
              tout_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + CNT_ONE;
              if (hit_stop) begin
                state_q <= ST_DONE;
                done_q  <= 1'b1;
              end
            end
          end
          default: ;  // result held until disable
        endcase
      end
    end
  end

  assign count_o   = cnt_q;
  assign done_o    = done_q;
  assign timeout_o = tout_q;
endmodule

// File: rtl/baud_edge_meter.sv
module baud_edge_meter #(
  parameter int CNT_W       = 20,
  parameter int START_W     = 3,
  parameter int STOP_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [START_W-1:0] start_idx_i,
  input  logic [STOP_W-1:0]  stop_idx_i,
  input  logic               rx_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               done_o,
  output logic               timeout_o
);
  logic              rise;
  logic              fall;
  logic              edge_v;
  logic [STOP_W-1:0] edge_idx;

  bm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  bm_edge_index #(.IDX_W(STOP_W)) u_index (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .rise_i (rise),
    .fall_i (fall),
    .edge_o (edge_v),
    .idx_o  (edge_idx)
  );

  bm_span_counter #(
    .CNT_W   (CNT_W),
    .START_W (START_W),
    .STOP_W  (STOP_W)
  ) u_span (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .edge_i      (edge_v),
    .idx_i       (edge_idx),
    .start_idx_i (start_idx_i),
    .stop_idx_i  (stop_idx_i),
    .count_o     (count_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );
endmodule

// File: rtl/baud_edge_meter_chk.sv
module baud_edge_meter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic             timeout_o
);
  logic fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  fin_q <= 1'b0;
    else if (!en_i)               fin_q <= 1'b0;
    else if (done_o || timeout_o) fin_q <= 1'b1;
  end

  assert_disable_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_o == '0 && !done_o && !timeout_o));

  assert_done_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> count_o != '0);

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_tout_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_tout_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> count_o == '1);

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_q && en_i && $past(en_i)) |-> ($stable(count_o) && !done_o && !timeout_o));

  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
endmodule

bind baud_edge_meter baud_edge_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .count_o   (count_o),
  .done_o    (done_o),
  .timeout_o (timeout_o)
);

// File: tb/baud_edge_meter_bench.sv
module baud_edge_meter_bench;
  localparam int CW = 12;  // narrow counter keeps overflow runs short

  typedef struct packed {
    logic          is_tout;
    logic [CW-1:0] val;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [2:0]    start_idx = '0;
  logic [3:0]    stop_idx = '0;
  logic          rx = 1'b1;
  logic [CW-1:0] count;
  logic          done;
  logic          tout;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];
  logic prev_done = 1'b0;
  logic prev_tout = 1'b0;
  int   cyc = 0;

  always #2.5 clk = ~clk;

  baud_edge_meter #(.CNT_W(CW)) u_baud_edge_meter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .start_idx_i (start_idx),
    .stop_idx_i  (stop_idx),
    .rx_i        (rx),
    .count_o     (count),
    .done_o      (done),
    .timeout_o   (tout)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(done && prev_done), "R4 done pulse width", int'(done), 0);
      chk(!(tout && prev_tout), "R5 timeout pulse width", int'(tout), 0);
      if (done && tout) chk(1'b0, "R8 both strobes", 1, 0);
      if (done || tout) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected strobe", int'(count), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(tout == e.is_tout, "R3/R5 result kind", int'(tout), int'(e.is_tout));
          chk(count == e.val, "R3/R5 result count", int'(count), int'(e.val));
        end
      end
      prev_done = done;
      prev_tout = tout;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic rearm(input int s, input int e);
    @(posedge clk); #1;
    en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    start_idx = 3'(s);
    stop_idx  = 4'(e);
    en = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic send_frames(input logic [7:0] c0, input logic [7:0] c1, input int nc, input int b);
    for (int k = 0; k < nc; k++) begin
      logic [7:0] c;
      c = (k == 0) ? c0 : c1;
      for (int p = 0; p < 10; p++) begin
        rx = (p == 0) ? 1'b0 : (p == 9) ? 1'b1 : c[p-1];
        repeat (b) @(posedge clk);
        #1;
      end
    end
    rx = 1'b1;
  endtask

  // driver: derive expectation from the line waveform, then send
  task automatic drive(input logic [7:0] c0, input logic [7:0] c1, input int nc,
                       input int b, input int s, input int e);
    int   epos[20];
    int   ne;
    logic prev;
    logic lv;
    exp_t x;
    ne = 0;
    prev = 1'b1;
    for (int k = 0; k < nc; k++) begin
      for (int p = 0; p < 10; p++) begin
        lv = (p == 0) ? 1'b0 : (p == 9) ? 1'b1 : ((k == 0) ? c0[p-1] : c1[p-1]);
        if (lv != prev) begin
          epos[ne] = k * 10 + p;
          ne++;
        end
        prev = lv;
      end
    end
    if (e > s && e < ne) begin
      x.is_tout = 1'b0;
      x.val = CW'((epos[e] - epos[s]) * b);
    end else begin
      x.is_tout = 1'b1;
      x.val = '1;
    end
    exp_q.push_back(x);
    send_frames(c0, c1, nc, b);
  endtask

  task automatic drain(input int limit, input string req);
    int k;
    k = 0;
    while (exp_q.size() != 0 && k < limit) begin
      @(posedge clk);
      k++;
    end
    #1;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    logic [CW-1:0] hold;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(count == 0 && !done && !tout, "R1 reset state", int'(count), 0);
    rst_n = 1'b1;

    // R3: 0x0D, rising to rising
    rearm(1, 5);
    drive(8'h0D, 8'h00, 1, 16, 1, 5);
    drain(400, "R3 0x0D result arrives");
    chk(count == CW'(8 * 16), "R3 0x0D held count", int'(count), 8 * 16);

    // R6: extra character ignored after done
    hold = count;
    send_frames(8'h7F, 8'h00, 1, 12);
    repeat (20) @(posedge clk);
    #1;
    chk(count == hold, "R6 count frozen after done", int'(count), int'(hold));

    // R1: disable clears, edges while disabled do nothing
    @(posedge clk); #1;
    en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(count == 0, "R1 disable clears count", int'(count), 0);
    send_frames(8'h0D, 8'h00, 1, 8);
    repeat (10) @(posedge clk);
    #1;
    chk(count == 0, "R1 disabled ignores line", int'(count), 0);

    // R3: 0x7F example
    rearm(1, 3);
    drive(8'h7F, 8'h00, 1, 12, 1, 3);
    drain(400, "R3 0x7F result arrives");

    // R2/R3: start at edge 0, other pattern and bit time
    rearm(0, 9);
    drive(8'h55, 8'h00, 1, 10, 0, 9);
    drain(400, "R2 0x55 result arrives");
    rearm(2, 4);
    drive(8'h0D, 8'h00, 1, 5, 2, 4);
    drain(200, "R2 falling to falling result");

    // R9: span two characters, end index 15
    rearm(7, 15);
    drive(8'h55, 8'h55, 2, 8, 7, 15);
    drain(400, "R9 two-character result");

    // R2: rising edge before first falling takes no index
    @(posedge clk); #1;
    en = 1'b0;
    rx = 1'b0;
    start_idx = 3'd1;
    stop_idx = 4'd5;
    repeat (4) @(posedge clk);
    #1;
    en = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    rx = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    drive(8'h0D, 8'h00, 1, 9, 1, 5);
    drain(300, "R2 leading rise ignored");

    // R5: too few edges
    rearm(0, 4);
    drive(8'hFF, 8'h00, 1, 10, 0, 4);
    drain(6000, "R5 too few edges timeout");
    chk(count == '1, "R5 count held at max", int'(count), (1 << CW) - 1);
    send_frames(8'h0D, 8'h00, 1, 6);
    repeat (10) @(posedge clk);
    #1;
    chk(count == '1, "R6 frozen after timeout", int'(count), (1 << CW) - 1);

    // R7: end index not above start index
    rearm(5, 3);
    drive(8'h55, 8'h00, 1, 10, 5, 3);
    drain(6000, "R7 end below start timeout");

    // R5: held break
    rearm(0, 1);
    begin
      exp_t x;
      x.is_tout = 1'b1;
      x.val = '1;
      exp_q.push_back(x);
    end
    rx = 1'b0;
    drain(6000, "R5 break timeout");
    rx = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk(!done && !tout && count == '1, "R6 release after break ignored", int'(count), (1 << CW) - 1);

    @(posedge clk); #1;
    en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(count == 0, "R1 final disable clears", int'(count), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule